// File: doc/BRIEF.md
# DMA Stream Request Splitter

This block sits between the control side of a DMA engine and its transfer backend. Both sides carry one-dimensional requests: a source address, a destination address, a byte length and an option field. One bus address is reserved to stand for the streaming port. When a request names that address as its source or destination, the block replaces the address meaning with option bits that steer the backend to the streaming port on that side.

When the streaming port is the read side, the total length is not known in advance. The sender may end the packet at any point with TLAST. The block therefore does not forward the full length. It issues a chain of single-unit backend requests of 4 bytes each. Each unit waits for its backend completion before the next is issued. The chain ends on the first completion that reports TLAST, or once the requested byte count has been moved. All other requests go to the backend unchanged as one request.

Each upstream request produces exactly one upstream completion.

Top module: `dma_stream_splitter`

## Requirements
- R1: After reset, `req_ready_o` is 1, and both `be_valid_o` and `done_valid_o` are 0.
- R2: Backend option bit 0 is 1 exactly when the upstream source equals `STREAM_ADDR`, which selects the stream port as the read side. Otherwise it is 0, which selects the memory port.
- R3: Backend option bit 1 is 1 exactly when the upstream destination equals `STREAM_ADDR`. Option bits above bit 1 are copied unchanged from the upstream request.
- R4: A request whose source is not the stream address produces exactly one backend request. That request carries the full length and the unmodified addresses.
- R5: A request whose source is the stream address produces backend requests of length min(4, remaining bytes). They are issued one at a time, and each one is issued only after the previous completion.
- R6: For each unit request, the memory-side address advances by 4. A side that is the stream address stays fixed.
- R7: A unit chain stops after the first backend completion that has `be_rsp_last_i` set, even if bytes remain.
- R8: Without TLAST, a unit chain stops once the units issued cover the full requested length.
- R9: A request with length 0 completes upstream without any backend request.
- R10: Exactly one completion (`done_valid_o`) follows each accepted request. It is held until `done_ready_i`. New requests are accepted only while no request is in progress.
- R11: A backend request that is not yet accepted keeps `be_valid_o` and all of its fields stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Upstream request valid |
| req_ready_o | output | 1 | Upstream request ready (idle) |
| req_src_i | input | AW | Upstream source address |
| req_dst_i | input | AW | Upstream destination address |
| req_len_i | input | LW | Upstream length in bytes |
| req_opt_i | input | OW | Upstream options (bits 1:0 are replaced) |
| be_valid_o | output | 1 | Backend request valid |
| be_ready_i | input | 1 | Backend request ready |
| be_src_o | output | AW | Backend source address |
| be_dst_o | output | AW | Backend destination address |
| be_len_o | output | LW | Backend length in bytes |
| be_opt_o | output | OW | Backend options with port selects |
| be_rsp_valid_i | input | 1 | Backend completion valid |
| be_rsp_ready_o | output | 1 | Backend completion ready |
| be_rsp_last_i | input | 1 | TLAST seen in the completed transfer |
| done_valid_o | output | 1 | Upstream completion valid |
| done_ready_i | input | 1 | Upstream completion ready |

## Verification
The port mapping is tried with four combinations of source and destination: memory to memory, memory to stream, stream to memory, and stream to stream. Only the cases where the source is the stream may split, and only a fixed side may keep its address.

Stream reads are tried with three lengths:
- a multiple of 4, which shows plain length termination;
- a length with a 2-byte tail, which exposes a wrong last-unit size;
- a long length cut short by TLAST in the third unit, which tells early ending apart from running to the full count.

A zero-length request and a backend that stalls its ready line cover the remaining corner cases.

// File: rtl/dma_stream_splitter_pkg.sv
package dma_stream_splitter_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_DONE  = 2'd3
  } split_state_e;
endpackage

// File: rtl/midend_port_map.sv
module midend_port_map #(
  parameter int unsigned AW = 32,
  parameter int unsigned OW = 4,
  parameter logic [AW-1:0] STREAM_ADDR = '1
) (
  input  logic [AW-1:0] src_i,
  input  logic [AW-1:0] dst_i,
  input  logic [OW-1:0] opt_i,
  output logic          src_stream_o,
  output logic          dst_stream_o,
  output logic [OW-1:0] opt_o
);
  assign src_stream_o = (src_i == STREAM_ADDR);
  assign dst_stream_o = (dst_i == STREAM_ADDR);

  generate
    if (OW > 2) begin : g_keep_upper
      assign opt_o = {opt_i[OW-1:2], dst_stream_o, src_stream_o};
    end else begin : g_sel_only
      assign opt_o = {dst_stream_o, src_stream_o};
    end
  endgenerate
endmodule

// File: rtl/midend_unit_tracker.sv
module midend_unit_tracker #(
  parameter int unsigned AW = 32,
  parameter int unsigned LW = 32,
  parameter int unsigned UNIT_BYTES = 4
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          load_i,
  input  logic [AW-1:0] src_i,
  input  logic [AW-1:0] dst_i,
  input  logic [LW-1:0] len_i,
  input  logic          src_fixed_i,
  input  logic          dst_fixed_i,
  input  logic          step_i,
  output logic [AW-1:0] cur_src_o,
  output logic [AW-1:0] cur_dst_o,
  output logic [LW-1:0] remain_o,
  output logic [LW-1:0] unit_len_o,
  output logic          last_unit_o
);
  localparam logic [LW-1:0] UNIT_L = LW'(UNIT_BYTES);
  localparam logic [AW-1:0] UNIT_A = AW'(UNIT_BYTES);

  logic src_fixed_q, dst_fixed_q;

  assign last_unit_o = (remain_o <= UNIT_L);
  assign unit_len_o  = last_unit_o ? remain_o : UNIT_L;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cur_src_o   <= '0;
      cur_dst_o   <= '0;
      remain_o    <= '0;
      src_fixed_q <= 1'b0;
      dst_fixed_q <= 1'b0;
    end else if (load_i) begin
      cur_src_o   <= src_i;
      cur_dst_o   <= dst_i;
      remain_o    <= len_i;
      src_fixed_q <= src_fixed_i;
      dst_fixed_q <= dst_fixed_i;
    end else if (step_i) begin
      remain_o <= remain_o - unit_len_o;
      if (!src_fixed_q) cur_src_o <= cur_src_o + UNIT_A;
      if (!dst_fixed_q) cur_dst_o <= cur_dst_o + UNIT_A;
    end
  end

  AST_STREAM_SRC_FIXED: assert property (@(posedge clk_i) disable iff (rst_i)
    step_i && !load_i && src_fixed_q |=> $stable(cur_src_o)); // R6
  AST_MEM_SRC_ADVANCE: assert property (@(posedge clk_i) disable iff (rst_i)
    step_i && !load_i && !src_fixed_q |=> cur_src_o == $past(cur_src_o) + UNIT_A); // R6
endmodule

// File: rtl/dma_stream_splitter.sv
module dma_stream_splitter
  import dma_stream_splitter_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned LW = 32,
  parameter int unsigned OW = 4,
  parameter int unsigned UNIT_BYTES = 4,
  parameter logic [AW-1:0] STREAM_ADDR = 32'h2000_3000
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [AW-1:0] req_src_i,
  input  logic [AW-1:0] req_dst_i,
  input  logic [LW-1:0] req_len_i,
  input  logic [OW-1:0] req_opt_i,
  output logic          be_valid_o,
  input  logic          be_ready_i,
  output logic [AW-1:0] be_src_o,
  output logic [AW-1:0] be_dst_o,
  output logic [LW-1:0] be_len_o,
  output logic [OW-1:0] be_opt_o,
  input  logic          be_rsp_valid_i,
  output logic          be_rsp_ready_o,
  input  logic          be_rsp_last_i,
  output logic          done_valid_o,
  input  logic          done_ready_i
);
  split_state_e state_q;
  logic          split_q;
  logic [OW-1:0] opt_q;
  logic          src_stream, dst_stream;
  logic [OW-1:0] opt_mapped;
  logic          accept, rsp_fire, load, step;
  logic [LW-1:0] remain, unit_len;
  logic          last_unit;

  midend_port_map #(
    .AW(AW), .OW(OW), .STREAM_ADDR(STREAM_ADDR)
  ) i_port_map (
    .src_i        (req_src_i),
    .dst_i        (req_dst_i),
    .opt_i        (req_opt_i),
    .src_stream_o (src_stream),
    .dst_stream_o (dst_stream),
    .opt_o        (opt_mapped)
  );

  assign accept   = req_valid_i && (state_q == ST_IDLE);
  assign rsp_fire = be_rsp_valid_i && (state_q == ST_WAIT);
  assign load     = accept;
  assign step     = rsp_fire;

  midend_unit_tracker #(
    .AW(AW), .LW(LW), .UNIT_BYTES(UNIT_BYTES)
  ) i_tracker (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .load_i      (load),
    .src_i       (req_src_i),
    .dst_i       (req_dst_i),
    .len_i       (req_len_i),
    .src_fixed_i (src_stream),
    .dst_fixed_i (dst_stream),
    .step_i      (step),
    .cur_src_o   (be_src_o),
    .cur_dst_o   (be_dst_o),
    .remain_o    (remain),
    .unit_len_o  (unit_len),
    .last_unit_o (last_unit)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state_q <= ST_IDLE;
      split_q <= 1'b0;
      opt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          split_q <= src_stream;
          opt_q   <= opt_mapped;
          state_q <= (req_len_i == '0) ? ST_DONE : ST_ISSUE;
        end
        ST_ISSUE: if (be_ready_i) state_q <= ST_WAIT;
        ST_WAIT: if (be_rsp_valid_i) begin
          state_q <= (!split_q || be_rsp_last_i || last_unit) ? ST_DONE : ST_ISSUE;
        end
        ST_DONE: if (done_ready_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o    = (state_q == ST_IDLE);
  assign be_valid_o     = (state_q == ST_ISSUE);
  assign be_rsp_ready_o = (state_q == ST_WAIT);
  assign done_valid_o   = (state_q == ST_DONE);
  assign be_len_o       = split_q ? unit_len : remain;
  assign be_opt_o       = opt_q;

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
    be_valid_o && !be_ready_i |=> be_valid_o && $stable(be_src_o) && $stable(be_dst_o) && $stable(be_len_o) && $stable(be_opt_o)); // R11
  AST_UNIT_LEN: assert property (@(posedge clk_i) disable iff (rst_i)
    be_valid_o && be_opt_o[0] |-> be_len_o != '0 && be_len_o <= LW'(UNIT_BYTES)); // R5
  AST_BUSY_NO_ACCEPT: assert property (@(posedge clk_i) disable iff (rst_i)
    req_ready_o |-> !be_valid_o && !done_valid_o); // R10
  AST_DONE_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
    done_valid_o && !done_ready_i |=> done_valid_o); // R10
  AST_ZERO_LEN: assert property (@(posedge clk_i) disable iff (rst_i)
    req_valid_i && req_ready_o && req_len_i == '0 |=> done_valid_o && !be_valid_o); // R9
  AST_NO_OPT_CHANGE_MIDWAY: assert property (@(posedge clk_i) disable iff (rst_i)
    be_rsp_valid_i && be_rsp_ready_o |=> $stable(be_opt_o)); // R2
endmodule

// File: tb/test_dma_stream_splitter.sv
module test_dma_stream_splitter;
  localparam int unsigned AW = 32;
  localparam int unsigned LW = 32;
  localparam int unsigned OW = 4;
  localparam logic [31:0] SADDR = 32'h2000_3000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, be_ready = 1'b0, rsp_valid = 1'b0, rsp_last = 1'b0, done_ready = 1'b0;
  logic [AW-1:0] req_src = '0, req_dst = '0;
  logic [LW-1:0] req_len = '0;
  logic [OW-1:0] req_opt = '0;
  logic req_ready, be_valid, rsp_ready, done_valid;
  logic [AW-1:0] be_src, be_dst;
  logic [LW-1:0] be_len;
  logic [OW-1:0] be_opt;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  dma_stream_splitter #(.AW(AW), .LW(LW), .OW(OW), .UNIT_BYTES(4), .STREAM_ADDR(SADDR)) i_dma_stream_splitter (
    .clk_i(clk), .rst_i(rst),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_src_i(req_src), .req_dst_i(req_dst), .req_len_i(req_len), .req_opt_i(req_opt),
    .be_valid_o(be_valid), .be_ready_i(be_ready),
    .be_src_o(be_src), .be_dst_o(be_dst), .be_len_o(be_len), .be_opt_o(be_opt),
    .be_rsp_valid_i(rsp_valid), .be_rsp_ready_o(rsp_ready), .be_rsp_last_i(rsp_last),
    .done_valid_o(done_valid), .done_ready_i(done_ready)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Runs one upstream request and models the backend.
  // last_at: unit index whose completion reports TLAST (-1 for none).
  // stall: hold backend ready low for one cycle on the first request.
  task automatic run_xfer(input string tag, input logic [31:0] src, input logic [31:0] dst,
                          input int len, input logic [3:0] opt, input int last_at, input bit stall);
    bit s_str = (src == SADDR);
    bit d_str = (dst == SADDR);
    int exp_units;
    int k = 0;
    int guard = 0;
    int rem;
    logic [3:0] exp_opt = {opt[3:2], d_str, s_str};
    if (len == 0) exp_units = 0;
    else if (!s_str) exp_units = 1;
    else begin
      exp_units = (len + 3) / 4;
      if (last_at >= 0 && last_at + 1 < exp_units) exp_units = last_at + 1;
    end
    check({tag, " R10 idle ready"}, req_ready, 1);
    req_src = src; req_dst = dst; req_len = len; req_opt = opt; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (!done_valid && guard < 200) begin
      if (be_valid) begin
        rem = len - 4 * k;
        check({tag, " R4/R5 length"}, be_len, s_str ? ((rem < 4) ? rem : 4) : len);
        check({tag, " R6 source addr"}, be_src, s_str ? src : src + 4 * k);
        check({tag, " R6 dest addr"}, be_dst, (d_str || !s_str) ? dst : dst + 4 * k);
        check({tag, " R2/R3 options"}, be_opt, exp_opt);
        if (stall && k == 0) begin
          @(negedge clk);
          check({tag, " R11 held valid"}, be_valid, 1);
          check({tag, " R11 held length"}, be_len, s_str ? ((len < 4) ? len : 4) : len);
        end
        be_ready = 1'b1;
        @(negedge clk);
        be_ready = 1'b0;
        check({tag, " R5 one outstanding"}, be_valid, 0);
        rsp_valid = 1'b1;
        rsp_last = (k == last_at);
        @(negedge clk);
        rsp_valid = 1'b0; rsp_last = 1'b0;
        k++;
      end else begin
        @(negedge clk);
      end
      guard++;
    end
    check({tag, " R7/R8/R9 backend request count"}, k, exp_units);
    check({tag, " R10 completion"}, done_valid, 1);
    check({tag, " R10 busy not ready"}, req_ready, 0);
    @(negedge clk);
    check({tag, " R10 completion held"}, done_valid, 1);
    done_ready = 1'b1;
    @(negedge clk);
    done_ready = 1'b0;
    check({tag, " R10 single completion"}, done_valid, 0);
    check({tag, " R10 back to idle"}, req_ready, 1);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 req_ready", req_ready, 1);
    check("R1 be_valid", be_valid, 0);
    check("R1 done_valid", done_valid, 0);
    rst = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    run_xfer("mem-mem R4", 32'h0000_1000, 32'h0000_2000, 16, 4'hC, -1, 0);
    run_xfer("mem-stream R3", 32'h0000_1100, SADDR, 12, 4'h4, -1, 0);
    run_xfer("stream-mem R8", SADDR, 32'h0000_3000, 16, 4'h8, -1, 0);
    run_xfer("stream-mem tail R5", SADDR, 32'h0000_4000, 10, 4'h0, -1, 0);
    run_xfer("stream-mem tlast R7", SADDR, 32'h0000_5000, 32, 4'h0, 2, 0);
    run_xfer("zero R9", SADDR, 32'h0000_6000, 0, 4'h0, -1, 0);
    run_xfer("stream-stream R6", SADDR, SADDR, 8, 4'hF, -1, 0);
    run_xfer("stall R11", SADDR, 32'h0000_7000, 8, 4'h0, -1, 1);
    run_xfer("mem-mem stall R11", 32'h0000_8000, 32'h0000_9000, 6, 4'h0, -1, 1);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule